// File: doc/BRIEF.md
# Dual-Mode Event Timer with Pulse/Toggle Output and Edge Capture

The block is a general-purpose up-counting timer with a software register port. A free-running counter advances on a timer clock enable, either directly or through a power-of-two divider. When it rolls over from all ones, it either reloads a programmable start value or halts. An optional compare stage flags the moment the counter reaches a programmed value.

The same counter value is latched into a capture register whenever a chosen edge appears on an asynchronous event input. That input first passes through a two-flop synchronizer. Overflow and match events can drive an output pin. The pin either emits a one-counter-clock pulse or toggles, and its rest level is set by software.

Three sticky flags record overflow, match and capture. They are cleared by writing ones. A per-flag mask selects which flags raise the wake-up request.

The counter runs a two-state machine. RUN_IDLE moves to RUN_COUNT on START, which is a control write with bit 0 set. RUN_COUNT moves back to RUN_IDLE on STOP, which is a control write with bit 0 clear, or on EXPIRE, which is an overflow with auto-reload off. The pin runs a second machine. PIN_REST moves to PIN_PULSE on PULSE_BEGIN, which is a trigger in pulse mode. PIN_PULSE moves back to PIN_REST on PULSE_END, which is the next counter advance that carries no trigger. Both leave for PIN_REST on DISARM, when the timer stops or the trigger mode is off.

Top module: `evtimer`

## Requirements
- R1: Control bit 0 reads 1 while counting. With the divider off, the counter rises by one on each cycle where `tick` is high. While stopped it holds its value. A write to address 1 loads the counter.
- R2: When control bit 5 is set, the counter advances once every 2^(P+1) ticks, where P is control bits 4:2. No advance happens on a cycle without a tick.
- R3: An advance from all ones sets flag bit 0. If control bit 1 is set, the counter then loads the value at address 2 and keeps running. Otherwise the counter becomes 0 and control bit 0 clears.
- R4: When control bit 6 is set, an advance whose new value equals the value at address 3 sets flag bit 1. When bit 6 is clear, flag bit 1 is never set.
- R5: Control bits 9:8 select the capture edge: 00 none, 01 rising, 10 falling, 11 both. A qualifying edge on `evt_in` is seen after two synchronizer stages. It copies the counter value into address 4 and sets flag bit 2.
- R6: Control bits 11:10 select the trigger: 01 fires on overflow only, 10 fires on overflow or match. Both 00 and 11 give no trigger.
- R7: When control bit 12 is 0, a trigger drives the pin to the inverse of the rest level until the next counter advance that carries no trigger. When it is 1, each trigger inverts the pin.
- R8: While the timer is stopped or no trigger is selected, the pin follows control bit 7. At other times, a change of bit 7 does not move the pin.
- R9: Flags at address 5 are sticky and cleared by writing 1. Setting a flag wins over clearing it in the same cycle. `wake_req` is high exactly when some flag is set whose bit is also set at address 6.
- R10: All registers reset to zero. Control bits 31:13 read as zero. Address 7 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer clock enable |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address (0 control, 1 count, 2 reload, 3 compare, 4 capture, 5 flags, 6 wake mask) |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Read data for `addr`, combinational |
| evt_in | input | 1 | Asynchronous event input |
| pwm_out | output | 1 | Trigger output pin |
| wake_req | output | 1 | Masked wake-up request |

## Verification
The counter is run with a steady tick, with a tick on every other cycle, and with the divider at ratios 2 and 8. These patterns separate a counter that counts clocks from one that counts enables, and expose an off-by-one in the divide ratio. The pin is exercised with toggle mode on overflow only and with pulse mode on overflow plus match. Changing the rest level in mid-run and selecting the reserved trigger code show whether each write reaches the pin only when it may. The event input is wiggled under each of the four capture selections, so a swapped edge decode or a missing synchronizer stage shows up as a wrong captured value or a flag in the wrong cycle.

// File: rtl/evtimer_pkg.sv
package evtimer_pkg;
    localparam int PRE_W  = 3;
    localparam int DIV_W  = 1 << PRE_W;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_COUNT  = 3'd1;
    localparam logic [ADDR_W-1:0] A_RELOAD = 3'd2;
    localparam logic [ADDR_W-1:0] A_MATCH  = 3'd3;
    localparam logic [ADDR_W-1:0] A_CAPT   = 3'd4;
    localparam logic [ADDR_W-1:0] A_FLAGS  = 3'd5;
    localparam logic [ADDR_W-1:0] A_WAKE   = 3'd6;

    typedef enum logic {RUN_IDLE, RUN_COUNT} run_state_e;
    typedef enum logic {PIN_REST, PIN_PULSE} pin_state_e;
    typedef enum logic [1:0] {TRG_OFF = 2'b00, TRG_OVF = 2'b01,
                              TRG_BOTH = 2'b10, TRG_RSVD = 2'b11} trg_e;

    // control word bits 12:1; bit 0 is the run state
    typedef struct packed {
        logic             toggle;
        trg_e             trg;
        logic [1:0]       capm;
        logic             pol;
        logic             cmp_en;
        logic             pre_en;
        logic [PRE_W-1:0] ptv;
        logic             reload_en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t) + 1;
endpackage

// File: rtl/evtimer_prescale.sv
module evtimer_prescale
    import evtimer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             pre_en,
    input  logic [PRE_W-1:0] ptv,
    output logic             step
);
    logic [DIV_W-1:0] pcnt;
    logic [DIV_W-1:0] lim;
    logic             wrap;

    always_comb begin
        lim  = DIV_W'((1 << (ptv + 1)) - 1);
        wrap = (pcnt == lim);
        step = pre_en ? (tick & wrap) : tick;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pcnt <= '0;
        end else if (tick) begin
            pcnt <= wrap ? '0 : pcnt + 1'b1;
        end
    end
endmodule

// File: rtl/evtimer_capture.sv
module evtimer_capture
    import evtimer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       evt_in,
    input  logic [1:0] capm,
    output logic       hit
);
    logic [2:0] shreg;
    logic       rise;
    logic       fall;

    always_ff @(posedge clk) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= {shreg[1:0], evt_in};
    end

    always_comb begin
        rise = shreg[1] & ~shreg[2];
        fall = ~shreg[1] & shreg[2];
        hit  = (capm[0] & rise) | (capm[1] & fall);
    end
endmodule

// File: rtl/evtimer_pin.sv
module evtimer_pin
    import evtimer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic toggle,
    input  logic pol,
    input  logic trig,
    input  logic step,
    output logic pin
);
    pin_state_e pst, pst_nx;
    logic       pin_nx;

    always_comb begin
        pst_nx = pst;
        pin_nx = pin;
        if (!active) begin                    // DISARM
            pst_nx = PIN_REST;
            pin_nx = pol;
        end else begin
            unique case (pst)
                PIN_REST: if (trig) begin
                    if (toggle) begin
                        pin_nx = ~pin;
                    end else begin            // PULSE_BEGIN
                        pin_nx = ~pol;
                        pst_nx = PIN_PULSE;
                    end
                end
                PIN_PULSE: if (step && !trig) begin   // PULSE_END
                    pin_nx = pol;
                    pst_nx = PIN_REST;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pst <= PIN_REST;
        else        pst <= pst_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pin <= 1'b0;
        else        pin <= pin_nx;
    end
endmodule

// File: rtl/evtimer.sv
module evtimer
    import evtimer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    input  logic              evt_in,
    output logic              pwm_out,
    output logic              wake_req
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    ctrl_t            ctrl;
    run_state_e       st, st_nx;
    logic [CNT_W-1:0] cnt, reload, cmpv, capv, nxt;
    logic [2:0]       flags, wmask, fclr;
    logic             running, step, adv, ovf, match, cap_hit, trig, pin_active;
    logic             wr_ctrl, wr_cnt;

    always_comb begin
        wr_ctrl = wr_en && (addr == A_CTRL);
        wr_cnt  = wr_en && (addr == A_COUNT);
        fclr    = (wr_en && (addr == A_FLAGS)) ? wdata[2:0] : 3'b000;
        running = (st == RUN_COUNT);
        adv     = running && step && !wr_cnt;
        ovf     = adv && (cnt == CNT_MAX);
        nxt     = ovf ? (ctrl.reload_en ? reload : '0) : cnt + 1'b1;
        match   = adv && ctrl.cmp_en && (nxt == cmpv);
        pin_active = running && (ctrl.trg == TRG_OVF || ctrl.trg == TRG_BOTH);
        trig    = (ovf && (ctrl.trg == TRG_OVF || ctrl.trg == TRG_BOTH)) ||
                  (match && ctrl.trg == TRG_BOTH);
    end

    // counter run-state transitions
    always_comb begin
        st_nx = st;
        unique case (st)
            RUN_IDLE:  if (wr_ctrl && wdata[0]) st_nx = RUN_COUNT;          // START
            RUN_COUNT: if (wr_ctrl && !wdata[0]) st_nx = RUN_IDLE;          // STOP
                       else if (!wr_ctrl && ovf && !ctrl.reload_en)
                           st_nx = RUN_IDLE;                                // EXPIRE
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= RUN_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl   <= '0;
            cnt    <= '0;
            reload <= '0;
            cmpv   <= '0;
            capv   <= '0;
            flags  <= '0;
            wmask  <= '0;
        end else begin
            if (wr_ctrl)                      ctrl   <= ctrl_t'(wdata[CTRL_W-1:1]);
            if (wr_en && addr == A_RELOAD)    reload <= wdata;
            if (wr_en && addr == A_MATCH)     cmpv   <= wdata;
            if (wr_en && addr == A_WAKE)      wmask  <= wdata[2:0];
            if (wr_cnt)                       cnt    <= wdata;
            else if (adv)                     cnt    <= nxt;
            if (cap_hit)                      capv   <= cnt;
            flags <= (flags & ~fclr) | {cap_hit, match, ovf};
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL:   rdata[CTRL_W-1:0] = {ctrl, running};
            A_COUNT:  rdata = cnt;
            A_RELOAD: rdata = reload;
            A_MATCH:  rdata = cmpv;
            A_CAPT:   rdata = capv;
            A_FLAGS:  rdata[2:0] = flags;
            A_WAKE:   rdata[2:0] = wmask;
            default:  rdata = '0;
        endcase
        wake_req = |(flags & wmask);
    end

    evtimer_prescale u_pre (
        .clk(clk), .rst_n(rst_n), .run(running), .tick(tick),
        .pre_en(ctrl.pre_en), .ptv(ctrl.ptv), .step(step)
    );

    evtimer_capture u_cap (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .capm(ctrl.capm), .hit(cap_hit)
    );

    evtimer_pin u_pin (
        .clk(clk), .rst_n(rst_n), .active(pin_active), .toggle(ctrl.toggle),
        .pol(ctrl.pol), .trig(trig), .step(step), .pin(pwm_out)
    );
endmodule

// File: rtl/evtimer_chk.sv
module evtimer_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             running,
    input logic             wr_cnt,
    input logic             wr_ctrl,
    input logic             tick,
    input logic             pre_en,
    input logic             cmp_en,
    input logic [1:0]       capm,
    input logic [1:0]       trg,
    input logic             pol,
    input logic             pwm_out,
    input logic [2:0]       flags,
    input logic             wake_req,
    input logic [CNT_W-1:0] cnt
);
    assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !wr_cnt) |=> $stable(cnt));

    assert_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_en && !tick && !wr_cnt) |=> $stable(cnt));

    assert_stop_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(running) |-> ($past(wr_ctrl) || $past(cnt) == {CNT_W{1'b1}}));

    assert_no_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_en |=> !$rose(flags[1]));

    assert_no_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (capm == 2'b00) |=> !$rose(flags[2]));

    assert_rest_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!running || trg == 2'b00 || trg == 2'b11) |=> (pwm_out == $past(pol)));

    assert_wake_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> (flags != 3'b000));
endmodule

bind evtimer evtimer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .running(running), .wr_cnt(wr_cnt),
    .wr_ctrl(wr_ctrl), .tick(tick), .pre_en(ctrl.pre_en), .cmp_en(ctrl.cmp_en),
    .capm(ctrl.capm), .trg(ctrl.trg), .pol(ctrl.pol), .pwm_out(pwm_out),
    .flags(flags), .wake_req(wake_req), .cnt(cnt)
);

// File: tb/tb_evtimer.sv
module tb_evtimer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd1;
    logic [31:0] wdata = '0;
    logic        evt_in = 1'b0;
    logic [31:0] rdata;
    logic        pwm_out;
    logic        wake_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    evtimer #(.CNT_W(32)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .evt_in(evt_in), .pwm_out(pwm_out),
        .wake_req(wake_req)
    );

    always #5 clk = ~clk;

    // behavioural reference model
    logic [12:0] m_ctrl;
    logic [31:0] m_cnt, m_rel, m_cmp, m_cap, nxt;
    logic [2:0]  m_flags, m_wen, m_sh;
    logic [7:0]  m_pcnt, lim;
    logic        m_pin, m_pulse;
    logic        stp, wcnt, adv, ovf, mt, rise, fall, cp, trig, act;
    logic [1:0]  trgm;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = '0; m_cnt = '0; m_rel = '0; m_cmp = '0; m_cap = '0;
            m_flags = '0; m_wen = '0; m_sh = '0; m_pcnt = '0;
            m_pin = 1'b0; m_pulse = 1'b0;
        end else begin
            lim  = 8'((32'd1 << (int'(m_ctrl[4:2]) + 1)) - 1);
            stp  = m_ctrl[5] ? (tick && m_pcnt == lim) : tick;
            wcnt = wr_en && addr == 3'd1;
            adv  = m_ctrl[0] && stp && !wcnt;
            ovf  = adv && m_cnt == 32'hFFFF_FFFF;
            nxt  = ovf ? (m_ctrl[1] ? m_rel : 32'd0) : m_cnt + 32'd1;
            mt   = adv && m_ctrl[6] && nxt == m_cmp;
            rise = m_sh[1] && !m_sh[2];
            fall = !m_sh[1] && m_sh[2];
            cp   = (m_ctrl[8] && rise) || (m_ctrl[9] && fall);
            trgm = m_ctrl[11:10];
            trig = (ovf && (trgm == 2'd1 || trgm == 2'd2)) || (mt && trgm == 2'd2);
            act  = m_ctrl[0] && (trgm == 2'd1 || trgm == 2'd2);
            if (!act) begin
                m_pin = m_ctrl[7]; m_pulse = 1'b0;
            end else if (!m_pulse) begin
                if (trig) begin
                    if (m_ctrl[12]) m_pin = !m_pin;
                    else begin m_pin = !m_ctrl[7]; m_pulse = 1'b1; end
                end
            end else if (stp && !trig) begin
                m_pin = m_ctrl[7]; m_pulse = 1'b0;
            end
            if (!m_ctrl[0]) m_pcnt = '0;
            else if (tick) m_pcnt = (m_pcnt == lim) ? 8'd0 : m_pcnt + 8'd1;
            if (cp) m_cap = m_cnt;
            m_flags = m_flags & ~((wr_en && addr == 3'd5) ? wdata[2:0] : 3'b000);
            m_flags = m_flags | {cp, mt, ovf};
            if (wcnt) m_cnt = wdata;
            else if (adv) m_cnt = nxt;
            if (wr_en && addr == 3'd0) m_ctrl = wdata[12:0];
            else if (ovf && !m_ctrl[1]) m_ctrl[0] = 1'b0;
            if (wr_en && addr == 3'd2) m_rel = wdata;
            if (wr_en && addr == 3'd3) m_cmp = wdata;
            if (wr_en && addr == 3'd6) m_wen = wdata[2:0];
            m_sh = {m_sh[1:0], evt_in};
        end
    end

    function automatic logic [31:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return {19'd0, m_ctrl};
            3'd1: return m_cnt;
            3'd2: return m_rel;
            3'd3: return m_cmp;
            3'd4: return m_cap;
            3'd5: return {29'd0, m_flags};
            3'd6: return {29'd0, m_wen};
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h at %0t", tag, got, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            #2;
            check("R7/R8 pin", {31'd0, pwm_out}, {31'd0, m_pin});
            check("R9 wake", {31'd0, wake_req}, {31'd0, |(m_flags & m_wen)});
            check("R1 read", rdata, m_read(addr));
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = 3'd1; wdata = '0;
    endtask

    task automatic rd_hand(input string tag, input logic [2:0] a, input logic [31:0] exp);
        @(negedge clk);
        addr = a;
        #3;
        check(tag, rdata, exp);
        addr = 3'd1;
    endtask

    function automatic logic [31:0] cw(input int tog, input int trg, input int capm,
        input int pol, input int ce, input int pre, input int ptv, input int ar, input int run);
        return 32'(tog << 12 | trg << 10 | capm << 8 | pol << 7 | ce << 6 |
                   pre << 5 | ptv << 2 | ar << 1 | run);
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    logic [31:0] hold;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick  = 1'b1;
        // R10: reset values
        rd_hand("R10 ctrl reset", 3'd0, 32'd0);
        rd_hand("R10 count reset", 3'd1, 32'd0);
        check("R10 pin reset", {31'd0, pwm_out}, 32'd0);
        // R1: plain counting, then stop and hold
        wr(3'd1, 32'd10);
        wr(3'd0, cw(0,0,0,0,0,0,0,0,1));
        idle(20);
        wr(3'd0, cw(0,0,0,0,0,0,0,0,0));
        @(negedge clk); #3 hold = rdata;
        idle(5);
        #3 check("R1 hold while stopped", rdata, hold);
        // R1: tick on every other cycle
        wr(3'd0, cw(0,0,0,0,0,0,0,0,1));
        for (int i = 0; i < 12; i++) begin @(negedge clk); tick = ~tick; end
        tick = 1'b1;
        // R2: divider by 2 then by 8
        wr(3'd0, cw(0,0,0,0,0,1,0,0,1));
        idle(20);
        wr(3'd0, cw(0,0,0,0,0,1,2,0,1));
        idle(40);
        // R3 / R6 / R7: toggle on overflow with auto-reload
        wr(3'd2, 32'hFFFF_FFF0);
        wr(3'd1, 32'hFFFF_FFF0);
        wr(3'd0, cw(1,1,0,0,0,0,0,1,1));
        idle(60);
        // R3: overflow without reload halts and clears run bit
        wr(3'd1, 32'hFFFF_FFFC);
        wr(3'd0, cw(0,0,0,0,0,0,0,0,1));
        idle(8);
        rd_hand("R3 run bit cleared", 3'd0, 32'd0);
        rd_hand("R3 count wrapped to zero", 3'd1, 32'd0);
        // R4 / R6 / R7: pulse on overflow or match, rest level high
        wr(3'd5, 32'd7);
        wr(3'd3, 32'hFFFF_FFF8);
        wr(3'd1, 32'hFFFF_FFF0);
        wr(3'd0, cw(0,2,0,1,1,0,0,1,1));
        idle(50);
        // R8: rest level change while armed does not move pin
        wr(3'd0, cw(0,2,0,0,1,0,0,1,1));
        idle(30);
        // R6: reserved trigger code behaves as off
        wr(3'd0, cw(0,3,0,1,1,0,0,1,1));
        idle(10);
        // R4: compare disabled gives no match flag
        wr(3'd5, 32'd7);
        wr(3'd0, cw(0,2,0,0,0,0,0,1,1));
        idle(40);
        // R5: each capture selection
        for (int m = 0; m < 4; m++) begin
            wr(3'd5, 32'd7);
            wr(3'd0, cw(0,0,m,0,0,0,0,1,1));
            for (int k = 0; k < 4; k++) begin
                @(negedge clk); evt_in = ~evt_in;
                idle(6);
            end
            rd_hand("R5 captured value", 3'd4, m_read(3'd4));
        end
        // R9: wake mask and write-one-to-clear
        wr(3'd6, 32'd4);
        idle(3);
        wr(3'd6, 32'd1);
        idle(3);
        wr(3'd0, cw(0,0,0,0,0,0,0,0,0));
        wr(3'd5, 32'd7);
        rd_hand("R9 flags cleared", 3'd5, 32'd0);
        // R10: reserved control bits ignore writes
        wr(3'd0, 32'hFFFF_E000);
        rd_hand("R10 reserved bits read zero", 3'd0, 32'd0);
        rd_hand("R10 unused address", 3'd7, 32'd0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule